// File: doc/BRIEF.md
# Four-Level Priority Bus Arbiter with Burst Preemption

This block decides which of several bus masters owns a shared bus. Every master presents a request bit together with a two-bit urgency level. Ownership goes to a requester at the highest level present, and a one-hot grant is issued. When several requesters share that top level, a mode input picks the tie-break. In the fixed mode the lowest index wins. In the rotating mode each level has its own pointer that rotates fairly among the masters.

A grant, once issued, is held until the owner reports that its transfer has finished. There is one exception. If a request above the owner's level waits continuously for a programmable number of cycles, the arbiter pulses a terminate signal to the owner for one cycle and then hands the bus to the waiting master. An owner that raises its lock line cannot be preempted, so an atomic sequence always completes. The block is meant to sit in front of an address/data multiplexer, and it drives that multiplexer's select through the grant vector.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zero and terminate is low.
- R2: The grant vector has at most one bit set. A newly issued grant goes only to a master whose request bit was high in the cycle before it appeared.
- R3: Master i's level is prio_i[2i+1:2i], and 3 is the most urgent level. At re-arbitration the winner is always a requester at the highest level among the active requests.
- R4: With rr_mode_i low, ties at the top level go to the lowest-index requester.
- R5: With rr_mode_i high, a tie at level L goes to the first requester at or after pointer[L], searching upward with wrap-around. Every grant at level L, in either mode, sets pointer[L] to the winner's index plus one, modulo the master count. All pointers reset to 0.
- R6: Once granted, the grant does not change until xfer_done_i is high or terminate_o has been high for a cycle, whatever other requests arrive.
- R7: Re-arbitration happens at the clock edge where xfer_done_i is high, at the edge after a terminate cycle, and at every edge while nothing is granted. The result appears in the grant on the following cycle.
- R8: Suppose a request above the owner's level is first seen at edge E0 and stays present, with the owner unlocked. Then terminate_o is high for exactly the single cycle after edge E0+C+1, where C = preempt_cnt_i, and the grant moves at edge E0+C+2.
- R9: While the current owner's lock_i bit is high, terminate_o stays low and the grant is held. When the lock drops, the countdown restarts from the full count.
- R10: If the higher-level request disappears before the countdown expires, no terminate is issued and the owner keeps the bus.
- R11: If xfer_done_i is high in the terminate cycle, exactly one re-arbitration occurs and the pointer of the winning level advances only once.
- R12: When no master requests at a re-arbitration edge, the grant becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NREQ | Per-master request |
| prio_i | input | 2*NREQ | Per-master level, two bits per master, 3 most urgent |
| lock_i | input | NREQ | Per-master lock; only the owner's bit matters |
| xfer_done_i | input | 1 | Owner has finished its transfer |
| rr_mode_i | input | 1 | 0 fixed tie-break, 1 rotating tie-break |
| preempt_cnt_i | input | TMR_W | Countdown loaded when higher-level work appears |
| grant_o | output | NREQ | One-hot grant, zero when idle |
| terminate_o | output | 1 | One-cycle order for the owner to end its burst |

## Verification
Two events can land in the same cycle: the owner may finish its transfer during the very cycle that the timer has ordered termination. The bench provokes this by raising xfer_done_i exactly in the terminate cycle, with two masters tied at the top level in rotating mode. It then checks that the grant lands on the first master of the rotation and that later completions walk the rotation without skipping. A skipped master would expose a double pointer advance. A second collision comes from holding the lock through the moment the countdown would have expired, which must yield no terminate and a full reload once the lock drops.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/arb_level_scan.sv
// Finds the most urgent level among active requests and marks the
// requesters sitting at that level.
module arb_level_scan
  import arb_pkg::*;
#(
  parameter int NREQ = 4
) (
  input  logic [NREQ-1:0]       req_i,
  input  logic [NREQ*LVL_W-1:0] prio_i,
  output logic                  any_o,
  output lvl_t                  top_lvl_o,
  output logic [NREQ-1:0]       top_mask_o
);
  lvl_t lvl_of [NREQ];

  for (genvar i = 0; i < NREQ; i++) begin : g_lvl
    assign lvl_of[i]     = prio_i[i*LVL_W +: LVL_W];
    assign top_mask_o[i] = req_i[i] && (lvl_of[i] == top_lvl_o);
  end

  always_comb begin
    top_lvl_o = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i] && (lvl_of[i] > top_lvl_o)) top_lvl_o = lvl_of[i];
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/arb_tie_pick.sv
// Chooses one master from a candidate mask: lowest index, or first at or
// after a rotation pointer with wrap-around.
module arb_tie_pick #(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NREQ-1:0]  mask_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic             rotate_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  int   cand;
  logic found;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int off = 0; off < NREQ; off++) begin
      cand = off;
      if (rotate_i) begin
        cand = int'(ptr_i) + off;
        if (cand >= NREQ) cand = cand - NREQ;
      end
      if (!found && mask_i[cand]) begin
        found = 1'b1;
        idx_o = IDX_W'(cand);
      end
    end
  end

  assign valid_o = |mask_i;
endmodule

// File: rtl/arb_preempt_timer.sv
// Counts down while more urgent work waits behind an unlocked owner and
// raises a one-cycle terminate when the count runs out.
module arb_preempt_timer
  import arb_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2,
  parameter int TMR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  owner_vld_i,
  input  logic [IDX_W-1:0]      owner_idx_i,
  input  lvl_t                  owner_lvl_i,
  input  logic [NREQ-1:0]       req_i,
  input  logic [NREQ*LVL_W-1:0] prio_i,
  input  logic [NREQ-1:0]       lock_i,
  input  logic [TMR_W-1:0]      reload_i,
  input  logic                  restart_i,
  output logic                  term_o
);
  logic [NREQ-1:0]  above_vec;
  logic             above_any;
  logic             owner_locked;
  logic             arm;

  logic             run_q, run_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             term_q, term_d;

  for (genvar i = 0; i < NREQ; i++) begin : g_above
    assign above_vec[i] = req_i[i] && (prio_i[i*LVL_W +: LVL_W] > owner_lvl_i);
  end

  assign above_any    = owner_vld_i && (|above_vec);
  assign owner_locked = lock_i[owner_idx_i];
  assign arm          = above_any && !owner_locked;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    term_d = 1'b0;
    if (restart_i) begin
      run_d = 1'b0;
    end else if (!arm) begin
      run_d = 1'b0;
    end else if (!run_q) begin
      run_d  = 1'b1;
      cnt_d  = reload_i;
      cnt_en = 1'b1;
    end else if (cnt_q == '0) begin
      run_d  = 1'b0;
      term_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      term_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      term_q <= term_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign term_o = term_q;
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int TMR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREQ-1:0]       req_i,
  input  logic [NREQ*LVL_W-1:0] prio_i,
  input  logic [NREQ-1:0]       lock_i,
  input  logic                  xfer_done_i,
  input  logic                  rr_mode_i,
  input  logic [TMR_W-1:0]      preempt_cnt_i,
  output logic [NREQ-1:0]       grant_o,
  output logic                  terminate_o
);
  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREQ - 1);

  logic             any_req;
  lvl_t             top_lvl;
  logic [NREQ-1:0]  top_mask;
  logic [IDX_W-1:0] ptr_sel;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] ptr_next;
  logic             term;
  logic             rearb;

  logic             own_vld_q, own_vld_d;
  logic [IDX_W-1:0] own_idx_q, own_idx_d;
  lvl_t             own_lvl_q, own_lvl_d;
  logic [NREQ-1:0]  grant_q, grant_d;
  logic             own_en;

  logic [IDX_W-1:0] rr_ptr_q [NUM_LVL];

  arb_level_scan #(.NREQ(NREQ)) u_scan (
    .req_i      (req_i),
    .prio_i     (prio_i),
    .any_o      (any_req),
    .top_lvl_o  (top_lvl),
    .top_mask_o (top_mask)
  );

  assign ptr_sel = rr_ptr_q[top_lvl];

  arb_tie_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
    .mask_i   (top_mask),
    .ptr_i    (ptr_sel),
    .rotate_i (rr_mode_i),
    .valid_o  (pick_vld),
    .idx_o    (pick_idx)
  );

  arb_preempt_timer #(.NREQ(NREQ), .IDX_W(IDX_W), .TMR_W(TMR_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .owner_vld_i (own_vld_q),
    .owner_idx_i (own_idx_q),
    .owner_lvl_i (own_lvl_q),
    .req_i       (req_i),
    .prio_i      (prio_i),
    .lock_i      (lock_i),
    .reload_i    (preempt_cnt_i),
    .restart_i   (rearb),
    .term_o      (term)
  );

  assign rearb = !own_vld_q || xfer_done_i || term;

  always_comb begin
    own_en    = rearb;
    own_vld_d = own_vld_q;
    own_idx_d = own_idx_q;
    own_lvl_d = own_lvl_q;
    grant_d   = grant_q;
    if (rearb) begin
      own_vld_d = pick_vld && any_req;
      own_idx_d = pick_idx;
      own_lvl_d = top_lvl;
      grant_d   = '0;
      if (pick_vld) grant_d[pick_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
      own_lvl_q <= '0;
      grant_q   <= '0;
    end else if (own_en) begin
      own_vld_q <= own_vld_d;
      own_idx_q <= own_idx_d;
      own_lvl_q <= own_lvl_d;
      grant_q   <= grant_d;
    end
  end

  assign ptr_next = (pick_idx == LAST_IDX) ? '0 : pick_idx + 1'b1;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_ptr
    logic ptr_en;
    assign ptr_en = rearb && pick_vld && (top_lvl == lvl_t'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rr_ptr_q[l] <= '0;
      end else if (ptr_en) begin
        rr_ptr_q[l] <= ptr_next;
      end
    end
  end

  assign grant_o     = grant_q;
  assign terminate_o = term;
endmodule

// File: rtl/prio_bus_arbiter_checker.sv
module prio_bus_arbiter_checker #(
  parameter int NREQ  = 4,
  parameter int TMR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREQ-1:0]   req_i,
  input logic [NREQ-1:0]   lock_i,
  input logic              xfer_done_i,
  input logic [NREQ-1:0]   grant_o,
  input logic              terminate_o
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r2_new_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && (grant_o != $past(grant_o))) |-> ((grant_o & $past(req_i)) != '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && !xfer_done_i && !terminate_o) |=> $stable(grant_o));

  a_r8_term_single: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |=> !terminate_o);

  a_r8_term_owned: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |-> (grant_o != '0));

  a_r9_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (((grant_o & lock_i) != '0) && !terminate_o) |=> !terminate_o);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o == '0) && (req_i == '0)) |=> (grant_o == '0));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_checker #(.NREQ(NREQ), .TMR_W(TMR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .lock_i      (lock_i),
  .xfer_done_i (xfer_done_i),
  .grant_o     (grant_o),
  .terminate_o (terminate_o)
);

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;
  localparam int N  = 4;
  localparam int TW = 8;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [2*N-1:0] prio;
  logic [N-1:0]  lock;
  logic          done;
  logic          rr;
  logic [TW-1:0] pcnt;
  logic [N-1:0]  grant;
  logic          term;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  int mptr [4];

  prio_bus_arbiter #(.NREQ(N), .TMR_W(TW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req),
    .prio_i        (prio),
    .lock_i        (lock),
    .xfer_done_i   (done),
    .rr_mode_i     (rr),
    .preempt_cnt_i (pcnt),
    .grant_o       (grant),
    .terminate_o   (term)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0; prio = '0; lock = '0; done = 1'b0;
    for (int l = 0; l < 4; l++) mptr[l] = 0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", int'(grant), 0);
    chk("R1 terminate in reset", int'(term), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go_idle();
    req = '0; lock = '0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
  endtask

  // expected one-hot grant from the requirement model
  function automatic int model_pick(input int rq, input int pv, input int rot);
    int top, w;
    top = -1; w = -1;
    for (int i = 0; i < N; i++)
      if (((rq >> i) & 1) == 1 && ((pv >> (2*i)) & 3) > top) top = (pv >> (2*i)) & 3;
    if (top < 0) return -1;
    for (int off = 0; off < N; off++) begin
      int c;
      c = (rot != 0) ? (mptr[top] + off) % N : off;
      if (w < 0 && ((rq >> c) & 1) == 1 && ((pv >> (2*c)) & 3) == top) w = c;
    end
    mptr[top] = (w + 1) % N;
    return w;
  endfunction

  // m0 at level 0 owns, m2 at level 3 arrives; optional lock on m0
  task automatic preempt_run(input int c, input bit locked_first);
    pcnt = TW'(c);
    req = 4'b0001; prio = '0; lock = locked_first ? 4'b0001 : 4'b0000;
    @(negedge clk);
    chk("R3 owner m0 granted", int'(grant), 1);
    req = 4'b0101; prio = 8'h30;
    if (locked_first) begin
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        chk("R9 locked no terminate", int'(term), 0);
        chk("R9 locked grant held", int'(grant), 1);
      end
      lock = '0;
    end
    for (int k = 1; k <= c + 1; k++) begin
      @(negedge clk);
      chk("R8 no early terminate", int'(term), 0);
      chk("R6 grant held while counting", int'(grant), 1);
    end
    @(negedge clk);
    chk("R8 terminate on expiry", int'(term), 1);
    chk("R8 grant kept in terminate cycle", int'(grant), 1);
    @(negedge clk);
    chk("R8 grant moved after terminate", int'(grant), 4);
    chk("R8 terminate single cycle", int'(term), 0);
    repeat (4) @(negedge clk);
    chk("R8 no terminate for top owner", int'(term), 0);
    go_idle();
  endtask

  initial begin
    int exp;
    rst_n = 1'b0; req = '0; prio = '0; lock = '0; done = 1'b0; rr = 1'b0; pcnt = '0;
    do_reset();

    // exhaustive sweep of request masks and level patterns, both modes
    for (int m = 0; m < 2; m++) begin
      rr = m[0];
      for (int rq = 0; rq < 16; rq++) begin
        for (int pv = 0; pv < 256; pv++) begin
          req = 4'(rq); prio = 8'(pv); done = 1'b0;
          exp = model_pick(rq, pv, m);
          @(negedge clk);
          if (m == 0) chk("R2 R3 R4 fixed pick", int'(grant), (exp < 0) ? 0 : (1 << exp));
          else        chk("R2 R3 R5 rotating pick", int'(grant), (exp < 0) ? 0 : (1 << exp));
          req = '0; done = 1'b1;
          @(negedge clk);
          chk("R7 R12 done to idle", int'(grant), 0);
        end
      end
    end
    done = 1'b0;

    do_reset();
    rr = 1'b0;
    preempt_run(3, 1'b0);
    preempt_run(0, 1'b0);
    preempt_run(2, 1'b1);

    // R10: higher request withdrawn before expiry
    pcnt = 8'd5;
    req = 4'b0001; prio = '0;
    @(negedge clk);
    chk("R10 owner m0", int'(grant), 1);
    req = 4'b0101; prio = 8'h30;
    repeat (3) @(negedge clk);
    req = 4'b0001;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R10 no terminate after withdraw", int'(term), 0);
      chk("R10 owner kept", int'(grant), 1);
    end
    go_idle();

    // R11: completion in the terminate cycle, rotating tie m2/m3 at level 3
    do_reset();
    rr = 1'b1; pcnt = 8'd2;
    req = 4'b0001; prio = '0;
    @(negedge clk);
    chk("R11 owner m0", int'(grant), 1);
    req = 4'b1101; prio = 8'hF0;
    for (int k = 1; k <= 3; k++) @(negedge clk);
    @(negedge clk);
    chk("R11 terminate cycle", int'(term), 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R11 single rearb picks m2", int'(grant), 4);
    chk("R11 terminate cleared", int'(term), 0);
    @(negedge clk);
    chk("R6 held after rearb", int'(grant), 4);
    done = 1'b1;
    @(negedge clk);
    chk("R5 rotation to m3", int'(grant), 8);
    @(negedge clk);
    done = 1'b0;
    chk("R5 rotation wraps to m2", int'(grant), 4);
    @(negedge clk);
    chk("R6 hold without done", int'(grant), 4);
    go_idle();
    chk("R12 idle grant", int'(grant), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 got=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule